// File: doc/BRIEF.md
# SPI Master/Slave Shift Engine

This block moves 8-bit frames over a four-wire SPI link, either as the bus master or as a slave. As a master it produces the serial clock from a programmable divider of the system clock. It can also pull its own active-low select line around each frame. As a slave it follows an external serial clock and select. Both of these arrive through two-flop synchronizers, so the slave's serial clock must run well below the system clock. Clock polarity, clock phase and bit order can each be configured. All three settings apply to both modes.

The parallel side is small. `tx_load` writes the byte to send into a holding register. `start` begins a master frame using the byte that was loaded in an earlier cycle. `rx_valid` pulses for one cycle with the received byte on `rx_data`. `busy` covers the whole master frame, including the select lead and tail, or the time the slave is selected. A slave takes its next byte from the holding register while it is deselected and again at the end of every frame. This lets a phase-1 slave run back-to-back frames without select ever going high.

Top module: `spi_engine`

## Requirements
- R1: After reset, busy=0, rx_valid=0, rx_data=0 and ss_n_o=1, and while the master is idle sck_o rests at cfg_cpol.
- R2: A master frame produces exactly 16 serial clock edges. Each half period lasts H = cfg_div+1 system clocks, and cfg_div=0 gives the fastest rate of one edge per system clock.
- R3: With cfg_auto_sel=1, ss_n_o is low in the cycle after start is accepted, and the first clock edge comes H cycles later. With cfg_auto_sel=0, ss_n_o stays high for the whole frame.
- R4: ss_n_o returns high, and busy falls in the same cycle, H cycles after the 16th edge, which is 17*H cycles after start is accepted. While the master drives ss_n_o low, busy is high.
- R5: With cfg_cpha=0, the first data bit is on the data output before the first edge. Odd-numbered edges (1,3..15) sample, and even-numbered edges change the output.
- R6: With cfg_cpha=1, odd-numbered edges change the output and even-numbered edges (2,4..16) sample. The first edge presents the first bit.
- R7: With cfg_lsb_first=0, bit 7 travels first and the first received bit lands in rx_data[7]. With cfg_lsb_first=1, bit 0 travels first and the first received bit lands in rx_data[0].
- R8: rx_valid is a one-cycle pulse with the complete byte on rx_data. It comes in the cycle after the eighth sample edge, which for a master is (15+cfg_cpha)*H cycles after start is accepted.
- R9: A slave drives miso_oe high only while its synchronized select is low. It receives the master's byte and returns the byte it held when it was selected.
- R10: With cfg_cpha=1 and select held low, a slave completes consecutive frames. The second frame sends the byte loaded during the first.
- R11: start is ignored while a master frame is in progress and whenever the block is a slave. The frame length is unchanged and a slave's sck_o and ss_n_o do not move.
- R12: tx_load during a master frame leaves that frame's transmitted bits unchanged, and the new byte is sent by the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| cfg_auto_sel | input | 1 | Master drives ss_n_o around each frame |
| cfg_div | input | DIV_W | Half-period length minus one, in system clocks |
| tx_data | input | FRAME | Byte to transmit |
| tx_load | input | 1 | Write tx_data into the holding register |
| start | input | 1 | Begin a master frame |
| busy | output | 1 | Frame in progress (master) or selected (slave) |
| rx_data | output | FRAME | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data updates |
| sck_o | output | 1 | Master serial clock |
| ss_n_o | output | 1 | Master active-low select |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock in |
| ss_n_i | input | 1 | Slave active-low select in |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Slave output enable |

## Verification
The hardest condition to reach is a phase-1 slave crossing a frame boundary with select still low. The master's automatic select always rises between frames. The master is therefore run with automatic select off, and the slave's select comes from a bench-driven line that stays low across two master frames. The slave's second byte is loaded partway through the first frame, so it is in place before the boundary reload. A bus monitor rebuilds the bytes from the wire at the sample edges it derives from polarity and phase. This catches edge-role and bit-order errors that would otherwise cancel out between the two instances.

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int FRAME = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_auto_sel,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FRAME-1:0] tx_data,
  input  logic             tx_load,
  input  logic             start,
  output logic             busy,
  output logic [FRAME-1:0] rx_data,
  output logic             rx_valid,
  output logic             sck_o,
  output logic             ss_n_o,
  output logic             mosi_o,
  input  logic             miso_i,
  input  logic             sck_i,
  input  logic             ss_n_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe
);
  localparam int EDGES = 2 * FRAME;
  localparam int CW    = $clog2(EDGES + 1);

  typedef enum logic [1:0] {M_IDLE, M_RUN, M_TAIL} mst_t;

  mst_t             mst;
  logic [DIV_W-1:0] div_cnt;
  logic [CW-1:0]    edge_cnt;
  logic             sck_r, ss_r, rx_v;
  logic [FRAME-1:0] tx_buf, tx_sh, rx_sh, rx_q;
  logic [2:0]       sck_s;
  logic [1:0]       ss_s, mosi_s;

  wire [CW-1:0] nxt    = edge_cnt + CW'(1);
  wire          sel    = ~ss_s[1];
  wire          tick   = (div_cnt == cfg_div);
  wire          m_ev   = cfg_master && (mst == M_RUN) && tick;
  wire          s_ev   = !cfg_master && sel && (sck_s[1] != sck_s[2]);
  wire          ev     = m_ev || s_ev;
  wire          lead   = cfg_master ? (sck_r == cfg_cpol) : (sck_s[2] == cfg_cpol);
  wire          smp    = ev && (lead ^ cfg_cpha);
  wire          fin    = ev && (nxt == CW'(EDGES));
  wire          shf    = ev && !(lead ^ cfg_cpha) && (nxt != CW'(1)) && !fin;
  wire          last_s = smp && (nxt >= CW'(EDGES - 1));
  wire          in_bit = cfg_master ? miso_i : mosi_s[1];
  wire          out_bit = cfg_lsb_first ? tx_sh[0] : tx_sh[FRAME-1];
  wire [FRAME-1:0] rx_nx = cfg_lsb_first ? {in_bit, rx_sh[FRAME-1:1]}
                                         : {rx_sh[FRAME-2:0], in_bit};
  wire          m_go   = cfg_master && start && (mst == M_IDLE);
  wire          idle   = cfg_master ? (mst == M_IDLE) : !sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      ss_s   <= '1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      ss_s   <= {ss_s[0], ss_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_buf <= '0;
    else if (tx_load) tx_buf <= tx_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_sh <= '0;
    else if (idle || (!cfg_master && fin)) tx_sh <= tx_buf;
    else if (shf) tx_sh <= cfg_lsb_first ? (tx_sh >> 1) : (tx_sh << 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh <= '0;
      rx_q  <= '0;
      rx_v  <= 1'b0;
    end else begin
      rx_v <= last_s;
      if (smp) rx_sh <= rx_nx;
      if (last_s) rx_q <= rx_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) edge_cnt <= '0;
    else if (fin || idle) edge_cnt <= '0;
    else if (ev) edge_cnt <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mst     <= M_IDLE;
      div_cnt <= '0;
      sck_r   <= 1'b0;
      ss_r    <= 1'b1;
    end else if (!cfg_master) begin
      mst     <= M_IDLE;
      div_cnt <= '0;
      sck_r   <= cfg_cpol;
      ss_r    <= 1'b1;
    end else begin
      case (mst)
        M_IDLE: begin
          sck_r   <= cfg_cpol;
          div_cnt <= '0;
          if (m_go) begin
            mst  <= M_RUN;
            ss_r <= !cfg_auto_sel;
          end
        end
        M_RUN: begin
          if (tick) begin
            div_cnt <= '0;
            sck_r   <= ~sck_r;
            if (nxt == CW'(EDGES)) mst <= M_TAIL;
          end else div_cnt <= div_cnt + DIV_W'(1);
        end
        M_TAIL: begin
          if (tick) begin
            div_cnt <= '0;
            mst     <= M_IDLE;
            ss_r    <= 1'b1;
          end else div_cnt <= div_cnt + DIV_W'(1);
        end
        default: mst <= M_IDLE;
      endcase
    end

  assign sck_o    = sck_r;
  assign ss_n_o   = ss_r;
  assign mosi_o   = cfg_master & out_bit;
  assign miso_oe  = !cfg_master && sel;
  assign miso_o   = miso_oe & out_bit;
  assign busy     = cfg_master ? (mst != M_IDLE) : sel;
  assign rx_data  = rx_q;
  assign rx_valid = rx_v;

  a_r4_sel_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !ss_n_o) |-> busy);

  a_r8_valid_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r3_select_leads_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $stable(cfg_master) && $fell(ss_n_o)) |-> (sck_o == cfg_cpol));

  a_r2_half_period_min: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && busy && cfg_div != '0 && $stable(cfg_div) && !$stable(sck_o))
      |=> $stable(sck_o));

  a_r1_idle_clock_level: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_master && $past(cfg_master) && !busy && $past(!busy)
      && $stable(cfg_cpol)) |-> (sck_o == cfg_cpol));
endmodule

// File: tb/sim_spi_engine.sv
module sim_spi_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cpol, cpha, lsb, auto_sel;
  logic [7:0] div, m_txd, s_txd;
  logic       m_ld, s_ld, m_start, s_start;
  logic       bench_ss, use_bench_ss;

  logic       m_busy, m_rxv, m_sck, m_ss, m_mosi, m_miso_o, m_oe;
  logic       s_busy, s_rxv, s_sck, s_ss, s_mosi, s_miso, s_oe;
  logic [7:0] m_rxd, s_rxd;
  wire        s_ss_in = use_bench_ss ? bench_ss : m_ss;

  spi_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_master(1'b1), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsb), .cfg_auto_sel(auto_sel), .cfg_div(div),
    .tx_data(m_txd), .tx_load(m_ld), .start(m_start), .busy(m_busy),
    .rx_data(m_rxd), .rx_valid(m_rxv), .sck_o(m_sck), .ss_n_o(m_ss),
    .mosi_o(m_mosi), .miso_i(s_miso), .sck_i(1'b0), .ss_n_i(1'b1),
    .mosi_i(1'b0), .miso_o(m_miso_o), .miso_oe(m_oe));

  spi_engine u1 (
    .clk(clk), .rst_n(rst_n), .cfg_master(1'b0), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsb), .cfg_auto_sel(1'b1), .cfg_div(8'd0),
    .tx_data(s_txd), .tx_load(s_ld), .start(s_start), .busy(s_busy),
    .rx_data(s_rxd), .rx_valid(s_rxv), .sck_o(s_sck), .ss_n_o(s_ss),
    .mosi_o(s_mosi), .miso_i(1'b0), .sck_i(m_sck), .ss_n_i(s_ss_in),
    .mosi_i(m_mosi), .miso_o(s_miso), .miso_oe(s_oe));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // bus monitor: rebuild bytes from the wire at sample edges
  logic       mon_on = 1'b0, prev_sck = 1'b0;
  int         mon_edges = 0;
  logic [7:0] mon_mosi = '0, mon_miso = '0;
  int         m_cnt = 0, s_cnt = 0;
  logic [7:0] m_hist [2];
  logic [7:0] s_hist [2];
  logic [7:0] m_last = '0, s_last = '0;

  always @(negedge clk) begin
    if (mon_on && m_sck != prev_sck) begin
      mon_edges++;
      if ((prev_sck == cpol) ^ cpha) begin
        mon_mosi = lsb ? {m_mosi, mon_mosi[7:1]} : {mon_mosi[6:0], m_mosi};
        mon_miso = lsb ? {s_miso, mon_miso[7:1]} : {mon_miso[6:0], s_miso};
      end
    end
    prev_sck = m_sck;
    if (m_rxv) begin m_hist[m_cnt % 2] = m_rxd; m_last = m_rxd; m_cnt++; end
    if (s_rxv) begin s_hist[s_cnt % 2] = s_rxd; s_last = s_rxd; s_cnt++; end
  end

  int t_edge, t_valid, t_done;
  bit ss_low_seen, oe_seen;

  task automatic xfer(input logic [7:0] mtx, input logic [7:0] stx, input bit ld_m,
                      input bit ld_s, input bit mid_m, input bit mid_s,
                      input logic [7:0] mid_val, input bit restart);
    int n;
    @(negedge clk);
    m_txd = mtx; s_txd = stx; m_ld = ld_m; s_ld = ld_s;
    @(negedge clk);
    m_ld = 1'b0; s_ld = 1'b0;
    mon_edges = 0; mon_mosi = '0; mon_miso = '0; mon_on = 1'b1;
    t_edge = -1; t_valid = -1; ss_low_seen = 1'b0; oe_seen = 1'b0;
    m_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_start = 1'b0;
    n = 0;
    while (n < 3000) begin
      if (m_sck != cpol && t_edge < 0) t_edge = n;
      if (m_rxv && t_valid < 0) t_valid = n;
      if (!m_ss) ss_low_seen = 1'b1;
      if (s_oe) oe_seen = 1'b1;
      if (!m_busy) break;
      if (n == 3) begin
        if (mid_m) begin m_txd = mid_val; m_ld = 1'b1; end
        if (mid_s) begin s_txd = mid_val; s_ld = 1'b1; end
      end else begin
        m_ld = 1'b0; s_ld = 1'b0;
      end
      m_start = restart && (n == 5);
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    m_start = 1'b0; m_ld = 1'b0; s_ld = 1'b0;
    t_done = n;
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
  endtask

  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'd4, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'd5, 8'h81, 8'h7E},
    {1'b1, 1'b0, 1'b0, 8'd4, 8'hC3, 8'h18},
    {1'b1, 1'b1, 1'b0, 8'd6, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 1'b1, 8'd4, 8'h01, 8'h80},
    {1'b0, 1'b1, 1'b1, 8'd7, 8'h96, 8'h69},
    {1'b1, 1'b0, 1'b1, 8'd5, 8'hE1, 8'h1E},
    {1'b1, 1'b1, 1'b1, 8'd4, 8'h5A, 8'hC7}
  };

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; lsb = 1'b0; auto_sel = 1'b1; div = 8'd4;
    m_txd = '0; s_txd = '0; m_ld = 1'b0; s_ld = 1'b0; m_start = 1'b0; s_start = 1'b0;
    bench_ss = 1'b1; use_bench_ss = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_busy == 1'b0, "R1 busy after reset", m_busy, 0);
    chk(m_rxv == 1'b0, "R1 rx_valid after reset", m_rxv, 0);
    chk(m_rxd == 8'h00, "R1 rx_data after reset", m_rxd, 0);
    chk(m_ss == 1'b1, "R1 ss_n_o after reset", m_ss, 1);
    chk(s_oe == 1'b0, "R9 slave oe while deselected", s_oe, 0);
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(m_sck == 1'b1, "R1 idle clock follows polarity", m_sck, 1);

    // table walk: master u0 against slave u1 in every mode
    for (int i = 0; i < 8; i++) begin
      logic [7:0] vd, vm, vs;
      int h;
      {cpol, cpha, lsb, vd, vm, vs} = VEC[i];
      div = vd; h = int'(vd) + 1;
      repeat (4) @(negedge clk);
      xfer(vm, vs, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      chk(mon_edges == 16, "R2 edge count", mon_edges, 16);
      chk(t_edge == h, "R3 select lead before first edge", t_edge, h);
      chk(ss_low_seen, "R3 auto select asserted", ss_low_seen, 1);
      chk(t_done == 17 * h, "R4 select release and busy fall", t_done, 17 * h);
      chk(t_valid == (15 + cpha) * h, "R8 rx_valid timing", t_valid, (15 + cpha) * h);
      chk(mon_mosi == vm, cpha ? "R6 R7 mosi bits on wire" : "R5 R7 mosi bits on wire", mon_mosi, vm);
      chk(mon_miso == vs, cpha ? "R6 R7 miso bits on wire" : "R5 R7 miso bits on wire", mon_miso, vs);
      chk(m_last == vs, "R8 master rx_data", m_last, vs);
      chk(s_last == vm, "R9 slave rx_data", s_last, vm);
      chk(oe_seen, "R9 slave oe while selected", oe_seen, 1);
      chk(s_oe == 1'b0, "R9 slave oe released", s_oe, 0);
    end

    // fastest divide: master alone
    cpol = 1'b0; cpha = 1'b0; lsb = 1'b0; div = 8'd0;
    repeat (4) @(negedge clk);
    xfer(8'h3E, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(mon_edges == 16, "R2 edges at minimum divide", mon_edges, 16);
    chk(t_done == 17, "R2 frame length at minimum divide", t_done, 17);
    chk(mon_mosi == 8'h3E, "R2 mosi at minimum divide", mon_mosi, 8'h3E);

    // start while busy is ignored
    div = 8'd4;
    repeat (4) @(negedge clk);
    xfer(8'h55, 8'hAA, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
    chk(t_done == 85, "R11 restart during frame ignored", t_done, 85);
    chk(mon_edges == 16, "R11 edge count with restart", mon_edges, 16);
    repeat (4) @(negedge clk);
    chk(m_busy == 1'b0, "R11 no second frame", m_busy, 0);

    // start on a slave is ignored
    @(negedge clk); s_start = 1'b1;
    @(negedge clk); s_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(s_ss == 1'b1, "R11 slave ss_n_o unchanged", s_ss, 1);
    chk(s_sck == cpol, "R11 slave sck_o unchanged", s_sck, cpol);
    chk(s_busy == 1'b0, "R11 slave stays idle", s_busy, 0);

    // load during frame: current frame unchanged, next frame uses new byte
    xfer(8'h6C, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 8'h93, 1'b0);
    chk(mon_mosi == 8'h6C, "R12 frame unchanged by mid load", mon_mosi, 8'h6C);
    xfer(8'h00, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(mon_mosi == 8'h93, "R12 next frame sends new byte", mon_mosi, 8'h93);

    // phase 1 slave with select held low over two frames
    cpha = 1'b1; cpol = 1'b0; lsb = 1'b0; auto_sel = 1'b0;
    use_bench_ss = 1'b1; bench_ss = 1'b1;
    repeat (4) @(negedge clk);
    s_txd = 8'hC5; s_ld = 1'b1;
    @(negedge clk); s_ld = 1'b0;
    bench_ss = 1'b0;
    repeat (4) @(negedge clk);
    m_cnt = 0; s_cnt = 0;
    xfer(8'h3A, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5E, 1'b0);
    chk(!ss_low_seen, "R3 no select with auto off", ss_low_seen, 0);
    chk(s_busy == 1'b1, "R10 slave still selected", s_busy, 1);
    xfer(8'hB4, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(s_cnt == 2, "R10 two slave frames", s_cnt, 2);
    chk(s_hist[0] == 8'h3A, "R10 slave first byte", s_hist[0], 8'h3A);
    chk(s_hist[1] == 8'hB4, "R10 slave second byte", s_hist[1], 8'hB4);
    chk(m_hist[0] == 8'hC5, "R10 master first byte", m_hist[0], 8'hC5);
    chk(m_hist[1] == 8'h5E, "R10 master second byte", m_hist[1], 8'h5E);
    bench_ss = 1'b1;
    repeat (4) @(negedge clk);
    chk(s_oe == 1'b0, "R9 oe released after select high", s_oe, 0);

    summary();
    $finish;
  end
endmodule